// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor and a line-oriented main memory. The processor issues single-byte reads and writes. Each address maps to exactly one cache line, picked by the index bits of its block address. Lines hold a valid flag, a modified flag, a tag and a data block. A write only touches the cached copy and marks the line as modified. Main memory learns about the change only when that line is evicted.

On a miss the processor waits. If the victim line is valid and modified, the whole line is first sent to memory at the block address rebuilt from its stored tag and the index. The missing block is then fetched. The line is installed clean and valid, and the access is retried. A write miss therefore finishes as a write hit. A clean victim is simply overwritten.

The processor presents a request for one cycle and then waits for a one-cycle completion pulse. The memory side holds each line transfer until the memory acknowledges it.

Top module: `dmc_cache`

## Requirements
- R1: A byte address splits, from the most significant end, into a tag (ADDR_W-IDX_W-OFS_W bits), a line index (IDX_W bits) and a byte offset (OFS_W bits). Addresses that differ only in offset share one line. Addresses with equal index but different tags compete for the same line.
- R2: After reset every line is invalid, so the first access to any line fetches it from memory.
- R3: A read that hits returns the byte selected by the offset from the indexed line, with no memory transfer.
- R4: A write that hits updates only that cached byte and marks the line modified; memory is not written.
- R5: A miss whose victim is invalid or unmodified performs exactly one line fetch (mem_we=0) at block address {tag, index} and no memory write.
- R6: A miss whose victim is valid and modified first writes the whole victim line (mem_we=1) at block address {stored tag, index}, and only then fetches the new line.
- R7: A fetched line becomes valid and unmodified with the new tag, and the access is retried. A write miss thus leaves the new byte in the cache while memory keeps the old value.
- R8: cpu_ready is high for exactly one cycle per request, in the cycle after the hit completes. mem_req, mem_we and mem_addr stay stable from the rise of mem_req until mem_ack.
- R9: Address, direction and write data are captured when cpu_req is accepted in the idle state. Changes on the processor inputs while the access is pending have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle request strobe, accepted when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Line transfer request, held until mem_ack |
| mem_we | output | 1 | 1 = line writeback, 0 = line fetch |
| mem_addr | output | ADDR_W-OFS_W | Block address of the transfer |
| mem_wline | output | 8*LINE_BYTES | Victim line data, byte k in bits [8k+7:8k] |
| mem_rline | input | 8*LINE_BYTES | Fetched line data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the current transfer |

## Verification
The hardest case to reach is a modified victim evicted by a conflicting tag. That needs a write to a line and then a later access with the same index but a different tag, before any other eviction cleans the line. The directed part builds this explicitly, including a write miss that then gets evicted. The random part draws tags from only four values over all indices, so conflicting evictions of modified lines happen constantly. Every read is compared with a flat byte model kept by the bench.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_COMPARE   = 2'd1,
    ST_WRITEBACK = 2'd2,
    ST_ALLOCATE  = 2'd3
  } dmc_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = valid_q[idx] & dirty_q[idx];
  assign rd_tag   = tag_q[idx];

  // R7
  fill_clean_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(idx)] && !dirty_q[$past(idx)]);

  // R4
  dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
    mark_dirty |=> dirty_q[$past(idx)]);

  // R7
  no_fill_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    !(fill_en && mark_dirty));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES      = 16,
  parameter int IDX_W      = 4,
  parameter int LINE_BYTES = 8,
  parameter int OFS_W      = 3,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              byte_we,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [7:0]        byte_data,
  input  logic              line_we,
  input  logic [LINE_W-1:0] line_data,
  output logic [LINE_W-1:0] rd_line
);
  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    logic [7:0] lane_q [LINES];
    logic       lane_we;
    logic [7:0] lane_wd;

    always_comb begin
      lane_we = line_we | (byte_we & (ofs == OFS_W'(g)));
      lane_wd = line_we ? line_data[g*8 +: 8] : byte_data;
    end

    always_ff @(posedge clk) begin
      if (lane_we) lane_q[idx] <= lane_wd;
    end

    assign rd_line[g*8 +: 8] = lane_q[idx];

    // R7
    lane_fill_chk: assert property (@(posedge clk) disable iff (rst)
      line_we |=> lane_q[$past(idx)] == $past(line_data[g*8 +: 8]));
  end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W     = 12,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 8,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFS_W,
  localparam int BLK_W     = ADDR_W - OFS_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_W-1:0]  mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic [LINE_W-1:0] mem_rline,
  input  logic              mem_ack
);
  import dmc_pkg::*;

  dmc_state_t        state;
  logic [ADDR_W-1:0] req_addr;
  logic              req_we;
  logic [7:0]        req_wdata;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [OFS_W-1:0]  req_ofs;
  logic              rd_valid, rd_dirty, hit;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic              fill_en, wr_hit;
  logic [7:0]        sel_byte;

  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx = req_addr[OFS_W +: IDX_W];
  assign req_ofs = req_addr[OFS_W-1:0];

  always_comb begin
    hit      = rd_valid && (rd_tag == req_tag);
    fill_en  = (state == ST_ALLOCATE) && mem_ack;
    wr_hit   = (state == ST_COMPARE) && hit && req_we;
    sel_byte = rd_line[{req_ofs, 3'b000} +: 8];
  end

  dmc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(req_idx),
    .fill_en(fill_en), .fill_tag(req_tag), .mark_dirty(wr_hit),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag)
  );

  dmc_data_store #(.LINES(LINES), .IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES),
                   .OFS_W(OFS_W)) u_data (
    .clk(clk), .rst(rst), .idx(req_idx),
    .byte_we(wr_hit), .ofs(req_ofs), .byte_data(req_wdata),
    .line_we(fill_en), .line_data(mem_rline), .rd_line(rd_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_addr  <= '0;
      req_we    <= 1'b0;
      req_wdata <= '0;
      cpu_rdata <= '0;
      cpu_ready <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wline <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            req_addr  <= cpu_addr;
            req_we    <= cpu_we;
            req_wdata <= cpu_wdata;
            state     <= ST_COMPARE;
          end
        end
        ST_COMPARE: begin
          if (hit) begin
            cpu_ready <= 1'b1;
            if (!req_we) cpu_rdata <= sel_byte;
            state <= ST_IDLE;
          end else if (rd_dirty) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {rd_tag, req_idx};
            mem_wline <= rd_line;
            state     <= ST_WRITEBACK;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= req_addr[ADDR_W-1:OFS_W];
            state    <= ST_ALLOCATE;
          end
        end
        ST_WRITEBACK: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            mem_addr <= req_addr[ADDR_W-1:OFS_W];
            state    <= ST_ALLOCATE;
          end
        end
        ST_ALLOCATE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state   <= ST_COMPARE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3
  quiet_hit_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req);

  // R7
  retry_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ALLOCATE) && mem_ack |=> (state == ST_COMPARE) && hit);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(req_addr) && $stable(req_wdata));
endmodule

// File: tb/dmc_cache_test.sv
`timescale 1ns/1ps
module dmc_cache_test;
  localparam int ADDR_W = 12;
  localparam int LINES = 16;
  localparam int LINE_BYTES = 8;
  localparam int OFS_W = 3;
  localparam int BLK_W = ADDR_W - OFS_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int NBYTES = 1 << ADDR_W;

  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, mem_req, mem_we;
  logic [BLK_W-1:0] mem_addr;
  logic [LINE_W-1:0] mem_wline;
  logic [LINE_W-1:0] mem_rline = '0;
  logic mem_ack = 0;

  int checks = 0, errors = 0;
  int n_fill = 0, n_wb = 0;
  logic [BLK_W-1:0] last_wb_blk = '0;
  logic [BLK_W-1:0] last_fill_blk = '0;
  logic [7:0] backing [NBYTES];
  logic [7:0] ref_mem [NBYTES];
  bit scramble = 0;

  always #2.5 clk = ~clk;

  dmc_cache #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
    .mem_ack(mem_ack)
  );

  function automatic logic [7:0] init_byte(int a);
    return 8'((a * 37 + 11) ^ (a >> 5));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // memory responder
  initial begin
    int lat = 2;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (lat == 0) begin
          if (mem_we) begin
            for (int k = 0; k < LINE_BYTES; k++)
              backing[{mem_addr, 3'(k)}] = mem_wline[k*8 +: 8];
            n_wb++;
            last_wb_blk = mem_addr;
          end else begin
            for (int k = 0; k < LINE_BYTES; k++)
              mem_rline[k*8 +: 8] = backing[{mem_addr, 3'(k)}];
            n_fill++;
            last_fill_blk = mem_addr;
          end
          mem_ack = 1;
          lat = 1 + int'($urandom % 3);
        end else lat--;
      end
    end
  end

  task automatic access(bit we, logic [ADDR_W-1:0] a, logic [7:0] wd,
                        output logic [7:0] rd);
    int t = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    if (scramble) begin
      cpu_we = ~we; cpu_addr = a ^ 12'h5A5; cpu_wdata = ~wd;
    end
    while (!cpu_ready && t < 1000) begin
      @(negedge clk);
      t++;
    end
    chk(cpu_ready, "R8 completion", int'(cpu_ready), 1);
    rd = cpu_rdata;
    if (we) ref_mem[a] = wd;
    @(negedge clk);
    chk(!cpu_ready, "R8 one-cycle ready", int'(cpu_ready), 0);
    cpu_we = 0;
  endtask

  task automatic rd_chk(logic [ADDR_W-1:0] a, string req);
    logic [7:0] d;
    access(0, a, 8'h00, d);
    chk(d == ref_mem[a], req, int'(d), int'(ref_mem[a]));
  endtask

  initial begin
    #(5.0 * 190000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int f0, w0;
    void'($urandom(32'd1234));
    for (int i = 0; i < NBYTES; i++) begin
      backing[i] = init_byte(i);
      ref_mem[i] = init_byte(i);
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R2 reset outputs", int'({cpu_ready, mem_req}), 0);

    // R2 R5: first read misses, one fetch at {tag,index}
    f0 = n_fill; w0 = n_wb;
    rd_chk(12'h010, "R2 cold read data");
    chk(n_fill == f0 + 1 && n_wb == w0, "R2 cold miss fetch", n_fill - f0, 1);
    chk(last_fill_blk == 9'h002, "R5 fetch block address", int'(last_fill_blk), 2);

    // R3 R1: same line, other offset -> hit, no traffic
    f0 = n_fill;
    rd_chk(12'h013, "R3 read hit data");
    chk(n_fill == f0 && n_wb == w0, "R1 same line no traffic", n_fill - f0, 0);

    // R4 write hit
    access(1, 12'h012, 8'hA5, d);
    chk(n_fill == f0 && n_wb == w0, "R4 write hit no traffic", n_wb - w0, 0);
    chk(backing[12'h012] == init_byte(12'h012), "R4 memory untouched",
        int'(backing[12'h012]), int'(init_byte(12'h012)));
    rd_chk(12'h012, "R4 write hit readback");

    // R6 dirty victim, conflicting tag same index
    rd_chk(12'h090, "R6 conflict read data");
    chk(n_wb == w0 + 1 && n_fill == f0 + 1, "R6 writeback then fetch", n_wb - w0, 1);
    chk(last_wb_blk == 9'h002, "R6 writeback address", int'(last_wb_blk), 2);
    chk(backing[12'h012] == 8'hA5, "R6 written-back byte", int'(backing[12'h012]), 8'hA5);

    // R5 clean victim
    w0 = n_wb; f0 = n_fill;
    rd_chk(12'h110, "R5 clean victim read");
    chk(n_wb == w0 && n_fill == f0 + 1, "R5 clean victim no write", n_wb - w0, 0);

    // R7 write miss allocates and completes as a hit
    access(1, 12'h198, 8'h3C, d);
    chk(n_fill == f0 + 2 && n_wb == w0, "R7 write miss fetch", n_fill - f0, 2);
    chk(backing[12'h198] == init_byte(12'h198), "R7 memory keeps old",
        int'(backing[12'h198]), int'(init_byte(12'h198)));
    f0 = n_fill;
    rd_chk(12'h198, "R7 write miss readback");
    chk(n_fill == f0, "R7 line now resident", n_fill - f0, 0);

    // R1 same index, tag 0: evicts the modified line at block 0x33
    rd_chk(12'h018, "R1 index alias read");
    chk(last_wb_blk == 9'h033 && backing[12'h198] == 8'h3C, "R1 alias eviction",
        int'(last_wb_blk), 9'h033);

    // R9 inputs changed while pending are ignored
    scramble = 1;
    access(1, 12'h220, 8'h77, d);
    scramble = 0;
    rd_chk(12'h220, "R9 captured write");
    rd_chk(12'h220 ^ 12'h5A5, "R9 scrambled address untouched");

    // random traffic, four tags over all indices
    for (int i = 0; i < 2500; i++) begin
      logic [ADDR_W-1:0] a;
      a = {3'b000, 2'($urandom), 4'($urandom), 3'($urandom)};
      if ($urandom % 2) access(1, a, 8'($urandom), d);
      else rd_chk(a, "R3 R6 R7 random read");
    end
    finish_run();
  end
endmodule